// File: doc/BRIEF.md
# CAN Receive Message Store with Host Window

This block holds received CAN frames until a host reads them. A frame-assembly stage sends each frame as a byte stream: a frame-info byte flagged by a start-of-frame strobe, then the identifier bytes, then the data bytes. The block works out the stored length of the message from the frame-info byte. It accepts the message only if the whole message fits in the free part of a circular byte RAM. Accepted messages sit back to back in that RAM, so short and long frames share the storage with no gaps.

The host never addresses the RAM directly. A fixed 13-byte register window at addresses 16 to 28 always shows the oldest stored message, starting with its frame-info byte. When the host issues a release command, the read start moves past that message, and the next message appears at the same addresses. A frame that does not fit is dropped and sets a sticky overrun flag, which a separate command clears. A message counter and an available flag report how many complete messages are waiting. A start-of-frame that arrives before the current frame is complete abandons the unfinished frame.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: After reset, msg_count is 0, rx_avail is 0, overrun is 0 and rd_data is 0.
- R2: Window address 16 returns the frame-info byte of the oldest message. Bit 7 is the extended-format flag, bit 6 is the remote flag and bits 3..0 are the data length code; bits 5 and 4 always read as 0 whatever was received.
- R3: A message has 3 descriptor bytes for a standard frame (bit 7 = 0) or 5 for an extended frame (bit 7 = 1), followed by min(code, 8) data bytes, or by no data bytes for a remote frame. So the first data byte sits at address 19 (standard) or address 21 (extended), in arrival order.
- R4: With rd_en high, rd_data shows on the next cycle the byte at (address − 16) from the start of the oldest unreleased message, for addresses 16..28; later messages stay hidden.
- R5: cmd_release with at least one message stored discards the oldest message, and the next one appears at address 16. With no messages stored, cmd_release has no effect.
- R6: A frame is stored only if its full length is at most 64 minus the bytes already held by stored messages. Otherwise the frame is discarded and overrun goes to 1 on the cycle after its start byte.
- R7: overrun stays 1 until cmd_clr_ovr is high. If a drop and cmd_clr_ovr fall in the same cycle, overrun stays 1.
- R8: msg_count rises by one on the cycle after the final byte of an accepted frame and falls by one on each effective release. rx_avail is 1 exactly when msg_count is non-zero.
- R9: Storage is circular: message bytes and window reads wrap from byte 63 to byte 0 with no loss or gap.
- R10: Bytes with rx_sof low are ignored when no accepted frame is open, which covers idle time and the remaining bytes of a dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_sof | input | 1 | The present byte is the frame-info byte of a new frame |
| rx_byte | input | 8 | Received frame byte |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W (5) | Host register address |
| rd_data | output | 8 | Registered read data |
| cmd_release | input | 1 | Discard the visible message |
| cmd_clr_ovr | input | 1 | Clear the overrun flag |
| rx_avail | output | 1 | At least one message is stored |
| overrun | output | 1 | Sticky: a frame was dropped for lack of space |
| msg_count | output | CNT_W (5) | Number of stored messages |

## Verification
Each result has a fixed delay. rd_data updates on the edge that samples rd_en. msg_count and rx_avail update on the edge that accepts the last byte of a frame, or on the edge that samples a release. overrun updates on the edge that samples the start byte of a frame that does not fit. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each value is taken one edge after its cause. A byte-exact model in the bench keeps the queue of accepted messages and the count of occupied bytes. The bench compares every valid window byte of the oldest message against that model, and sweeps all combinations of frame format, remote flag and length code while the storage wraps many times.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

  localparam int RXF_BYTE_W  = 8;
  localparam int RXF_LEN_W   = 4;
  localparam int RXF_MAX_DAT = 8;

  // Stored length of a message, derived from its frame-info byte.
  function automatic logic [RXF_LEN_W-1:0] rxf_msg_len(input logic [RXF_BYTE_W-1:0] info);
    logic [RXF_LEN_W-1:0] hdr;
    logic [RXF_LEN_W-1:0] body;
    hdr  = info[7] ? 4'd5 : 4'd3;
    body = (info[3:0] > 4'(RXF_MAX_DAT)) ? 4'(RXF_MAX_DAT) : info[3:0];
    if (info[6]) body = 4'd0;
    return hdr + body;
  endfunction

  // Frame-info byte as stored: the two unused bits forced to zero.
  function automatic logic [RXF_BYTE_W-1:0] rxf_info_clean(input logic [RXF_BYTE_W-1:0] info);
    return {info[7:6], 2'b00, info[3:0]};
  endfunction

endpackage

// File: rtl/can_rxf_ram.sv
module can_rxf_ram #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/can_rxf_assembler.sv
module can_rxf_assembler
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic                 rx_sof,
  input  logic [7:0]           rx_byte,
  input  logic [AW:0]          free_bytes,
  output logic                 ram_we,
  output logic [AW-1:0]        ram_waddr,
  output logic [7:0]           ram_wdata,
  output logic                 commit,
  output logic [RXF_LEN_W-1:0] commit_len,
  output logic                 drop
);

  logic                 active;
  logic [RXF_LEN_W-1:0] idx;
  logic [RXF_LEN_W-1:0] len_q;
  logic [AW-1:0]        wr_base;

  logic                 sof_go;
  logic                 fits;
  logic                 accept;
  logic                 cont;
  logic [RXF_LEN_W-1:0] new_len;

  always_comb begin
    sof_go    = rx_valid && rx_sof;
    new_len   = rxf_msg_len(rx_byte);
    fits      = ({{(AW+1-RXF_LEN_W){1'b0}}, new_len} <= free_bytes);
    accept    = sof_go && fits;
    drop      = sof_go && !fits;
    cont      = rx_valid && !rx_sof && active;
    ram_we    = accept || cont;
    ram_waddr = accept ? wr_base : wr_base + AW'(idx);
    ram_wdata = accept ? rxf_info_clean(rx_byte) : rx_byte;
    commit    = cont && (idx == len_q - 4'd1);
    commit_len = len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      len_q   <= '0;
      wr_base <= '0;
    end else if (accept) begin
      active <= 1'b1;
      idx    <= 4'd1;
      len_q  <= new_len;
    end else if (drop) begin
      active <= 1'b0;
    end else if (cont) begin
      if (commit) begin
        active  <= 1'b0;
        wr_base <= wr_base + AW'(len_q);
      end else begin
        idx <= idx + 4'd1;
      end
    end
  end

endmodule

// File: rtl/can_rxf_window.sv
module can_rxf_window
  import can_rxf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 5,
  parameter int WIN_BASE = 16,
  parameter int WIN_SIZE = 13,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rel_go,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [AW-1:0]        win_raddr,
  input  logic [7:0]           win_rdata,
  output logic [AW-1:0]        head_ptr,
  input  logic [7:0]           head_info,
  output logic [RXF_LEN_W-1:0] rel_len,
  output logic [7:0]           rd_data
);

  logic              in_win;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    in_win    = (rd_addr >= ADDR_W'(WIN_BASE)) && (rd_addr < ADDR_W'(WIN_BASE + WIN_SIZE));
    offset    = rd_addr - ADDR_W'(WIN_BASE);
    win_raddr = head_ptr + AW'(offset);
    rel_len   = rxf_msg_len(head_info);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      rd_data  <= '0;
    end else begin
      if (rel_go) head_ptr <= head_ptr + AW'(rel_len);
      if (rd_en)  rd_data  <= in_win ? win_rdata : 8'h00;
    end
  end

endmodule

// File: rtl/can_rx_msg_fifo.sv
module can_rx_msg_fifo
  import can_rxf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 5,
  parameter int WIN_BASE = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH / 3 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_byte,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              cmd_release,
  input  logic              cmd_clr_ovr,
  output logic              rx_avail,
  output logic              overrun,
  output logic [CNT_W-1:0]  msg_count
);

  localparam int WIN_SIZE = 5 + RXF_MAX_DAT;

  logic [AW:0]          used;
  logic [AW:0]          free_bytes;
  logic                 ram_we;
  logic [AW-1:0]        ram_waddr;
  logic [7:0]           ram_wdata;
  logic [AW-1:0]        win_raddr;
  logic [7:0]           win_rdata;
  logic [AW-1:0]        head_ptr;
  logic [7:0]           head_info;
  logic [RXF_LEN_W-1:0] rel_len;
  logic [RXF_LEN_W-1:0] commit_len;
  logic                 commit_evt;
  logic                 drop_evt;
  logic                 release_go;

  assign free_bytes = (AW+1)'(DEPTH) - used;
  assign release_go = cmd_release && (msg_count != '0);
  assign rx_avail   = (msg_count != '0);

  can_rxf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr_a (win_raddr),
    .rdata_a (win_rdata),
    .raddr_b (head_ptr),
    .rdata_b (head_info)
  );

  can_rxf_assembler #(.DEPTH(DEPTH)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_byte    (rx_byte),
    .free_bytes (free_bytes),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .commit     (commit_evt),
    .commit_len (commit_len),
    .drop       (drop_evt)
  );

  can_rxf_window #(
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_go    (release_go),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .win_raddr (win_raddr),
    .win_rdata (win_rdata),
    .head_ptr  (head_ptr),
    .head_info (head_info),
    .rel_len   (rel_len),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used      <= '0;
      msg_count <= '0;
      overrun   <= 1'b0;
    end else begin
      used <= used
            + (commit_evt ? (AW+1)'(commit_len) : '0)
            - (release_go ? (AW+1)'(rel_len)    : '0);
      msg_count <= msg_count + CNT_W'(commit_evt) - CNT_W'(release_go);
      if (drop_evt)         overrun <= 1'b1;
      else if (cmd_clr_ovr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/can_rxf_checker.sv
module can_rxf_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW:0]      used,
  input logic [CNT_W-1:0] msg_count,
  input logic             commit_evt,
  input logic [3:0]       commit_len,
  input logic             release_go,
  input logic [3:0]       rel_len,
  input logic             drop_evt,
  input logic             overrun,
  input logic             cmd_clr_ovr
);

  assert_used_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));

  assert_commit_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> ({1'b0, used} + (AW+2)'(commit_len) <= (AW+2)'(DEPTH)));

  assert_drop_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !cmd_clr_ovr) |=> overrun);

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_ovr && !drop_evt) |=> !overrun);

  assert_release_covered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_go |-> (used >= (AW+1)'(rel_len)));

  assert_empty_holds_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_count == '0) |-> (used == '0));

endmodule

bind can_rx_msg_fifo can_rxf_checker #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .used        (used),
  .msg_count   (msg_count),
  .commit_evt  (commit_evt),
  .commit_len  (commit_len),
  .release_go  (release_go),
  .rel_len     (rel_len),
  .drop_evt    (drop_evt),
  .overrun     (overrun),
  .cmd_clr_ovr (cmd_clr_ovr)
);

// File: tb/tb_can_rx_msg_fifo.sv
module tb_can_rx_msg_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_sof = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = 5'd0;
  logic [7:0] rd_data;
  logic       cmd_release = 1'b0;
  logic       cmd_clr_ovr = 1'b0;
  logic       rx_avail;
  logic       overrun;
  logic [4:0] msg_count;

  int checks = 0;
  int errors = 0;

  // Bench model of the stored messages
  logic [7:0] mq_bytes [32][13];
  int         mq_len [32];
  int         m_head = 0;
  int         m_tail = 0;
  int         m_cnt  = 0;
  int         m_used = 0;
  bit         m_ovr  = 1'b0;

  always #10 clk = ~clk;

  can_rx_msg_fifo dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_sof      (rx_sof),
    .rx_byte     (rx_byte),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .cmd_release (cmd_release),
    .cmd_clr_ovr (cmd_clr_ovr),
    .rx_avail    (rx_avail),
    .overrun     (overrun),
    .msg_count   (msg_count)
  );

  function automatic int tb_len(input logic [7:0] info);
    int n;
    n = int'(info[3:0]);
    if (n > 8) n = 8;
    if (info[6] == 1'b1) n = 0;
    return n + (info[7] ? 5 : 3);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R1: watchdog expired actual=running expected=done");
    finish_sim();
  end

  task automatic send_frame(input logic [7:0] info, input int seed, input bit clr_at_sof);
    logic [7:0] b [13];
    int l;
    l = tb_len(info);
    b[0] = info;
    for (int k = 1; k < 13; k++) b[k] = 8'((seed * 29 + k * 11 + 5) & 255);
    if (l <= 64 - m_used) begin
      mq_bytes[m_tail][0] = info & 8'hCF;
      for (int k = 1; k < 13; k++) mq_bytes[m_tail][k] = b[k];
      mq_len[m_tail] = l;
      m_tail = (m_tail + 1) % 32;
      m_cnt++;
      m_used += l;
    end else begin
      m_ovr = 1'b1;
    end
    for (int k = 0; k < l; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (k == 0);
      rx_byte  = b[k];
      cmd_clr_ovr = (k == 0) && clr_at_sof;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
    cmd_clr_ovr = 1'b0;
  endtask

  task automatic read_byte(input int addr, output logic [7:0] val);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 5'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic do_release();
    @(negedge clk);
    cmd_release = 1'b1;
    @(negedge clk);
    cmd_release = 1'b0;
    if (m_cnt > 0) begin
      m_used -= mq_len[m_head];
      m_head = (m_head + 1) % 32;
      m_cnt--;
    end
  endtask

  task automatic check_status(input string tag);
    check({tag, " R8 msg_count"}, int'(msg_count), m_cnt);
    check({tag, " R8 rx_avail"}, int'(rx_avail), (m_cnt != 0) ? 1 : 0);
    check({tag, " R6 overrun"}, int'(overrun), int'(m_ovr));
  endtask

  // Compares every valid byte of the oldest message in the window
  task automatic check_head(input string tag);
    logic [7:0] v;
    for (int k = 0; k < mq_len[m_head]; k++) begin
      read_byte(16 + k, v);
      if (k == 0) check({tag, " R2 info byte"}, int'(v), int'(mq_bytes[m_head][0]));
      else        check({tag, " R3 R4 R9 window byte"}, int'(v), int'(mq_bytes[m_head][k]));
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 msg_count", int'(msg_count), 0);
    check("R1 rx_avail", int'(rx_avail), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 rd_data", int'(rd_data), 0);

    // R2 R3 R4 R5 R9: sweep of format, remote flag and length code, two messages at a time
    for (int i = 0; i < 64; i += 2) begin
      logic [7:0] ia;
      logic [7:0] ib;
      ia = {i[5], i[4], 2'(i), 4'(i)};
      ib = {i[4], i[5], 2'(i + 3), 4'(i + 1)};
      send_frame(ia, i, 1'b0);
      send_frame(ib, i + 100, 1'b0);
      check_status("sweep");
      check_head("sweep oldest R4");
      do_release();
      check_status("sweep R5 after release");
      check_head("sweep next R5");
      do_release();
      check_status("sweep drained");
    end

    // R10: stray bytes with no open frame are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = 1'b0;
      rx_byte  = 8'(8'hA0 + k);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check("R10 stray bytes count", int'(msg_count), 0);

    // R6: fill with four 13-byte messages, fifth dropped
    for (int k = 0; k < 4; k++) send_frame(8'h88, 200 + k, 1'b0);
    check_status("fill R6 four stored");
    send_frame(8'h88, 210, 1'b0);
    check_status("fill R6 fifth dropped");
    // R6: 12-byte message fits exactly in the remaining space
    send_frame(8'h87, 220, 1'b0);
    check_status("fill R6 exact fit");
    // R7: drop coinciding with clear keeps overrun set
    send_frame(8'h03, 230, 1'b1);
    check("R7 set beats clear", int'(overrun), 1);
    check_status("fill R6 full drop");
    // R7: plain clear
    @(negedge clk);
    cmd_clr_ovr = 1'b1;
    @(negedge clk);
    cmd_clr_ovr = 1'b0;
    m_ovr = 1'b0;
    check("R7 clear overrun", int'(overrun), 0);
    // R10: dropped frames left no bytes behind; drain in order
    while (m_cnt > 0) begin
      check_head("drain R10");
      do_release();
      check_status("drain");
    end

    // R5: release while empty has no effect
    do_release();
    check("R5 empty release count", int'(msg_count), 0);
    send_frame(8'h45, 300, 1'b0);
    check_status("after empty release R5");
    check_head("after empty release R5");
    read_byte(16, v);
    check("R2 masked bits 5:4", int'(v[5:4]), 0);
    do_release();
    check_status("final");

    finish_sim();
  end

endmodule